// File: doc/BRIEF.md
# Command-Word SPI Master

This block is a single-lane SPI master. A host programs it through a small register port and then writes words to a data register. Each word is shifted out on MOSI while MISO is captured, framed by one active-low select line. A 16-bit command register sets the frame format and timing of every word: clock polarity and phase, bit order, word length, an extra rate divider, the select-hold option, and enables for three programmable pauses. The pauses fall between select assertion and the first clock edge, between the last clock edge and select release, and between select release and the next select assertion.

The command word, rate and delay settings are taken when a word is launched. A one-word transmit buffer lets the host queue the next word while the current one shifts. A one-word receive buffer holds the captured word until the host reads it. A control register selects transmit-only operation, inverting or non-inverting internal loopback, a forced MOSI level outside the shifting phase, and the two interrupt enables.

Top module: `spi_cmd_master`

## Requirements
- R1: Registers sit at `bus_addr` 0 control, 1 rate, 2 command, 3 delays, 4 data, 5 status, and reads return the value combinationally. Out of reset, `ss_n` is 1, `sck` is 0, both interrupts are 0 and status reads 0x62.
- R2: While a word shifts, successive SCK edges are H = (N+1)·2^B clocks apart. N is the 8-bit rate register and B is command bits 3:2.
- R3: Command bits 11:8 give the word length. Codes 7..15 give code+1 bits, codes 0, 1 and 2 give 20, 24 and 32 bits, and codes 3..6 give 8 bits. Exactly that many bits are sent and received.
- R4: Command bit 1 is the SCK idle level and bit 0 the phase. With phase 0, data is valid before the leading edge and sampled on it. With phase 1, data changes on the leading edge and is sampled on the trailing edge. Command bit 12 set sends and stores the least significant bit first, otherwise the most significant bit first.
- R5: The delay register holds three 3-bit fields: bits 2:0 lead, bits 6:4 trail, bits 10:8 gap. Each pause is D = field+1 SCK periods when its enable (command bit 15 lead, 14 trail, 13 gap) is set, else D = 1. The first SCK edge comes (2·Dlead+1)·H clocks after `ss_n` falls. `ss_n` rises 2·Dtrail·H clocks after the last edge. A queued word drops `ss_n` again 2·Dgap·H clocks after it rose.
- R6: A finished word appears at the data register with receive-full (status bit 7) set. Reading the data register clears receive-full.
- R7: A word that finishes while receive-full is set is dropped, the held word is kept and overrun (status bit 0) is set. Writing the status register with bit 0 = 0 clears overrun.
- R8: With control bit 1 (transmit-only) set, words still shift out but receive-full never sets.
- R9: Control bit 4 feeds the inverted MOSI back as receive data. Control bit 5 feeds MOSI back unchanged and takes precedence. In both cases the MISO pin is ignored.
- R10: With control bit 6 set, MOSI outside the shifting phase equals control bit 7.
- R11: A data write clears transmit-empty (status bit 5) until the word is launched. Control bit 0 must be 1 for a launch. Transmit-end (bit 6) is 1 when nothing shifts and nothing is queued. Idle (bit 1) is 1 when the select is released and no pause runs.
- R12: With command bit 7 set, `ss_n` stays low after a word, including into the next word. Clearing that bit releases the select through the gap pause.
- R13: `irq_rx` equals receive-full AND control bit 2. `irq_tx` equals transmit-empty AND control bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (data-register read side effect) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| irq_rx | output | 1 | Receive interrupt |
| irq_tx | output | 1 | Transmit interrupt |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| ss_n | output | 1 | Active-low select |
| miso | input | 1 | Serial data in |

## Verification
The bench builds the block with its default 8-bit rate field. It runs most traffic at rate 0 with no extra division, so one SCK half-period is a single clock. That makes the full cross of all sixteen length codes, both bit orders and all four clock modes cheap. A bench-side slave monitor captures MOSI on the sampling edge and drives MISO on the other edge, and it times every edge. A second sweep covers rate values up to 255 with all four extra dividers. A third sweep covers every delay field with its enable on and off, and checks lead, trail and gap against the arithmetic formulas.

// File: rtl/spi_cmd_master.sv
module spi_cmd_master #(
  parameter int RATE_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq_rx,
  output logic        irq_tx,
  output logic        sck,
  output logic        mosi,
  output logic        ss_n,
  input  logic        miso
);
  localparam int WORD_W = 32;
  localparam int IDX_W  = $clog2(WORD_W);
  localparam int HC_W   = IDX_W + 1;
  localparam int HALF_W = RATE_W + 4;
  localparam int DLY_W  = 3;
  localparam int DC_W   = DLY_W + 2;

  localparam logic [2:0] A_CTRL = 3'd0, A_RATE = 3'd1, A_CMD = 3'd2,
                         A_DLY  = 3'd3, A_DATA = 3'd4, A_STAT = 3'd5;

  typedef enum logic [2:0] {S_IDLE, S_LEAD, S_XFER, S_TRAIL, S_GAP, S_HOLD} st_t;

  st_t               st;
  logic [7:0]        ctrl_q;
  logic [RATE_W-1:0] rate_q;
  logic [15:0]       cmd_q, cmd_l;
  logic [DLY_W-1:0]  dly_lead, dly_trail, dly_gap;
  logic [WORD_W-1:0] tx_buf, tx_word, rx_word, rx_buf, rx_nx;
  logic              tx_pend, rx_full, ovr, sck_r, mosi_r;
  logic [HALF_W-1:0] hcnt, half_len;
  logic [DC_W-1:0]   dcnt, d_tgt;
  logic [HC_W-1:0]   hc;
  logic [5:0]        len;
  logic [IDX_W-1:0]  bi, drive_idx;
  logic              tick, dly_done, last_half, drive_now, samp_now;
  logic              launch_ok, go, deliver, wr_data, rd_data, miso_eff, active;
  wire               unused_cmd = ^cmd_l[6:4];

  function automatic logic [5:0] wlen(input logic [3:0] c);
    case (c)
      4'd0: wlen = 6'd20;
      4'd1: wlen = 6'd24;
      4'd2: wlen = 6'd32;
      4'd3, 4'd4, 4'd5, 4'd6: wlen = 6'd8;
      default: wlen = {2'b00, c} + 6'd1;
    endcase
  endfunction

  function automatic logic [IDX_W-1:0] bitpos(input logic [IDX_W-1:0] idx,
                                              input logic lsbf, input logic [5:0] n);
    bitpos = lsbf ? idx : IDX_W'(n - 6'd1 - {1'b0, idx});
  endfunction

  function automatic logic [DC_W-1:0] dly_halves(input logic en, input logic [DLY_W-1:0] f);
    logic [DLY_W:0] p;
    p = {1'b0, f} + 1'b1;
    dly_halves = en ? {p, 1'b0} : DC_W'(2);
  endfunction

  assign wr_data   = bus_wr && bus_addr == A_DATA;
  assign rd_data   = bus_rd && bus_addr == A_DATA;
  assign len       = wlen(cmd_l[11:8]);
  assign half_len  = (HALF_W'(rate_q) + HALF_W'(1)) << cmd_l[3:2];
  assign active    = st == S_LEAD || st == S_XFER || st == S_TRAIL || st == S_GAP;
  assign tick      = active && hcnt == half_len - 1'b1;

  always_comb begin
    case (st)
      S_LEAD:  d_tgt = dly_halves(cmd_l[15], dly_lead);
      S_TRAIL: d_tgt = dly_halves(cmd_l[14], dly_trail);
      default: d_tgt = dly_halves(cmd_l[13], dly_gap);
    endcase
  end
  assign dly_done  = tick && dcnt == d_tgt - 1'b1;

  assign bi        = hc[HC_W-1:1];
  assign last_half = {1'b0, hc} == {len, 1'b0} - 7'd1;
  assign drive_now = tick && st == S_XFER && (cmd_l[0] ? !hc[0] : (hc[0] && !last_half));
  assign drive_idx = cmd_l[0] ? bi : bi + 1'b1;
  assign samp_now  = tick && st == S_XFER && (cmd_l[0] ? hc[0] : !hc[0]);
  assign deliver   = tick && st == S_XFER && last_half && !ctrl_q[1];

  assign launch_ok = ctrl_q[0] && tx_pend;
  assign go        = launch_ok && (st == S_IDLE || st == S_HOLD || (st == S_GAP && dly_done));

  assign mosi      = (st != S_XFER && ctrl_q[6]) ? ctrl_q[7] : mosi_r;
  assign miso_eff  = ctrl_q[5] ? mosi : (ctrl_q[4] ? ~mosi : miso);
  assign ss_n      = st == S_IDLE || st == S_GAP;
  assign sck       = st == S_IDLE ? cmd_q[1] : (st == S_XFER ? sck_r : cmd_l[1]);
  assign irq_rx    = rx_full && ctrl_q[2];
  assign irq_tx    = !tx_pend && ctrl_q[3];

  always_comb begin
    rx_nx = rx_word;
    if (samp_now) rx_nx[bitpos(bi, cmd_l[12], len)] = miso_eff;
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = 32'(ctrl_q);
      A_RATE:  bus_rdata = 32'(rate_q);
      A_CMD:   bus_rdata = 32'(cmd_q);
      A_DLY:   bus_rdata = 32'({dly_gap, 1'b0, dly_trail, 1'b0, dly_lead});
      A_DATA:  bus_rdata = rx_buf;
      A_STAT:  bus_rdata = 32'({rx_full, (st == S_IDLE || st == S_HOLD) && !tx_pend,
                                !tx_pend, 3'b000, st == S_IDLE, ovr});
      default: bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ctrl_q <= '0; rate_q <= '0; cmd_q <= '0; cmd_l <= '0;
      dly_lead <= '0; dly_trail <= '0; dly_gap <= '0;
      tx_buf <= '0; tx_word <= '0; rx_word <= '0; rx_buf <= '0;
      tx_pend <= 1'b0; rx_full <= 1'b0; ovr <= 1'b0; sck_r <= 1'b0; mosi_r <= 1'b0;
      hcnt <= '0; dcnt <= '0; hc <= '0;
    end else begin
      if (bus_wr) begin
        case (bus_addr)
          A_CTRL: ctrl_q <= bus_wdata[7:0];
          A_RATE: rate_q <= bus_wdata[RATE_W-1:0];
          A_CMD:  cmd_q  <= bus_wdata[15:0];
          A_DLY: begin
            dly_lead  <= bus_wdata[2:0];
            dly_trail <= bus_wdata[6:4];
            dly_gap   <= bus_wdata[10:8];
          end
          A_STAT: if (!bus_wdata[0]) ovr <= 1'b0;
          default: ;
        endcase
      end

      if (wr_data) begin
        tx_buf  <= bus_wdata;
        tx_pend <= 1'b1;
      end else if (go) begin
        tx_pend <= 1'b0;
      end

      if (deliver) begin
        if (rx_full && !rd_data) ovr <= 1'b1;
        else begin
          rx_buf  <= rx_nx;
          rx_full <= 1'b1;
        end
      end else if (rd_data) begin
        rx_full <= 1'b0;
      end

      if (active) hcnt <= tick ? '0 : hcnt + 1'b1;
      else        hcnt <= '0;

      if (go) begin
        st      <= S_LEAD;
        cmd_l   <= cmd_q;
        tx_word <= tx_buf;
        rx_word <= '0;
        hcnt    <= '0;
        dcnt    <= '0;
      end else begin
        case (st)
          S_LEAD: if (tick) begin
            if (dly_done) begin
              st    <= S_XFER;
              dcnt  <= '0;
              hc    <= '0;
              sck_r <= cmd_l[1];
              if (!cmd_l[0]) mosi_r <= tx_word[bitpos('0, cmd_l[12], len)];
            end else dcnt <= dcnt + 1'b1;
          end
          S_XFER: if (tick) begin
            sck_r   <= ~sck_r;
            rx_word <= rx_nx;
            if (drive_now) mosi_r <= tx_word[bitpos(drive_idx, cmd_l[12], len)];
            if (last_half) begin
              st   <= S_TRAIL;
              dcnt <= '0;
            end else hc <= hc + 1'b1;
          end
          S_TRAIL: if (tick) begin
            if (dly_done) begin
              st   <= (cmd_l[7] && ctrl_q[0]) ? S_HOLD : S_GAP;
              dcnt <= '0;
            end else dcnt <= dcnt + 1'b1;
          end
          S_GAP: if (tick) begin
            if (dly_done) st <= S_IDLE;
            else dcnt <= dcnt + 1'b1;
          end
          S_HOLD: if (!cmd_q[7] || !ctrl_q[0]) begin
            st   <= S_GAP;
            dcnt <= '0;
          end
          default: ;
        endcase
      end
    end
  end

  a_r2_sck_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_XFER && !tick) |=> $stable(sck));
  a_r6_rx_fills_at_word_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> $past(st) == S_XFER);
  a_r7_overrun_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(rx_full));
  a_r8_txonly_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[1] && !rx_full) |=> !rx_full);
  a_r11_write_queues: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> tx_pend);
  a_r10_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[6] && ss_n) |-> mosi == ctrl_q[7]);
endmodule

// File: tb/sim_spi_cmd_master.sv
module sim_spi_cmd_master;
  localparam int CLK_P = 10;
  localparam logic [2:0] A_CTRL = 3'd0, A_RATE = 3'd1, A_CMD = 3'd2,
                         A_DLY  = 3'd3, A_DATA = 3'd4, A_STAT = 3'd5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq_rx, irq_tx, sck, mosi, ss_n, miso;

  spi_cmd_master u0 (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_rx(irq_rx), .irq_tx(irq_tx), .sck(sck), .mosi(mosi), .ss_n(ss_n), .miso(miso));

  always #(CLK_P/2) clk = ~clk;

  int n_tests = 0, n_fail = 0;
  int m_cpol = 0, m_cpha = 0, m_lsbf = 0, m_len = 8, m_half = 1, rate = 0;
  int cyc = 0, fall_cyc = 0, rise_cyc = 0, last_edge = 0, ecnt = 0, scnt = 0;
  int lead_obs = 0, trail_obs = 0, gap_obs = 0, hmis = 0, rises = 0, words = 0;
  logic p_ss = 1'b1, p_sck = 1'b0;
  logic [31:0] cap = '0, cap_word = '0, sword = '0;

  always @(negedge clk) begin
    cyc++;
    if (ss_n && !p_ss) begin rise_cyc = cyc; trail_obs = cyc - last_edge; rises++; end
    if (!ss_n && p_ss) begin gap_obs = cyc - rise_cyc; fall_cyc = cyc; ecnt = 0; end
    if (!ss_n && sck !== p_sck) begin
      if (ecnt == 0) lead_obs = cyc - fall_cyc;
      else if (cyc - last_edge != m_half) hmis++;
      last_edge = cyc;
      ecnt++;
      if ((m_cpha != 0) ? (int'(p_sck) != m_cpol) : (int'(p_sck) == m_cpol)) begin
        cap[(m_lsbf != 0) ? scnt : m_len - 1 - scnt] = mosi;
        scnt++;
        if (scnt == m_len) begin cap_word = cap; cap = '0; scnt = 0; words++; end
      end
      if (ecnt == 2 * m_len) ecnt = 0;
    end
    p_ss = ss_n;
    p_sck = sck;
  end

  always_comb begin
    if (scnt < m_len) miso = sword[(m_lsbf != 0) ? scnt : m_len - 1 - scnt];
    else miso = 1'b0;
  end

  function automatic int wlen(input int c);
    if (c == 0) return 20;
    if (c == 1) return 24;
    if (c == 2) return 32;
    if (c < 7) return 8;
    return c + 1;
  endfunction

  function automatic logic [31:0] lmask(input int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic set_cmd(input logic [15:0] c);
    m_cpol = int'(c[1]); m_cpha = int'(c[0]); m_lsbf = int'(c[12]);
    m_len = wlen(int'(c[11:8])); m_half = (rate + 1) << c[3:2];
    wr(A_CMD, 32'(c));
  endtask

  task automatic wait_end();
    logic [31:0] s;
    do rd(A_STAT, s); while (!s[6]);
  endtask

  task automatic send(input logic [31:0] tx, input logic [31:0] sw);
    sword = sw; scnt = 0;
    wr(A_DATA, tx);
    wait_end();
  endtask

  task automatic flush();
    logic [31:0] v;
    rd(A_DATA, v);
    wr(A_STAT, 32'h0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v, tx, sw;
    int r0, w0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(A_STAT, v);
    check("R1 status", v, 32'h62);
    check("R1 ss_n", 32'(ss_n), 32'h1);
    check("R1 sck", 32'(sck), 32'h0);
    check("R1 irqs", 32'({irq_rx, irq_tx}), 32'h0);

    // R3 R4 R6: all lengths, orders and modes at H = 1
    wr(A_CTRL, 32'h1);
    hmis = 0;
    for (int mode = 0; mode < 4; mode++)
      for (int lsb = 0; lsb < 2; lsb++)
        for (int code = 0; code < 16; code++) begin
          tx = 32'h9E37_79B9 * 32'(mode * 32 + lsb * 16 + code + 1);
          sw = 32'h7F4A_7C15 ^ (tx << 3) ^ 32'(code);
          set_cmd(16'((code << 8) | (lsb << 12) | mode));
          send(tx, sw);
          check("R3 R4 mosi word", cap_word, tx & lmask(m_len));
          rd(A_DATA, v);
          check("R3 R4 R6 received word", v, sw & lmask(m_len));
        end
    check("R2 edge spacing H=1", 32'(hmis), 32'h0);
    rd(A_STAT, v);
    check("R6 read clears full", 32'(v[7]), 32'h0);

    // R2 R5: rate and divider sweep, delays disabled
    for (int k = 0; k < 5; k++)
      for (int b = 0; b < 4; b++) begin
        rate = (k == 4) ? 255 : ((k == 3) ? 6 : k);
        if (k == 4 && b != 0) continue;
        wr(A_RATE, 32'(rate));
        set_cmd(16'(32'h0702 | (b << 2)));
        hmis = 0;
        send(32'h0000_00C5, 32'h0000_003A);
        check("R2 edge spacing", 32'(hmis), 32'h0);
        check("R5 lead default", 32'(lead_obs), 32'(3 * m_half));
        check("R5 trail default", 32'(trail_obs), 32'(2 * m_half));
        flush();
      end
    rate = 0;
    wr(A_RATE, 32'h0);

    // R5: delay field sweep with enables on and off
    for (int en = 0; en < 2; en++)
      for (int f = 0; f < 8; f++) begin
        int dl, dt, dg;
        wr(A_DLY, 32'(f | ((7 - f) << 4) | (((f + 3) & 7) << 8)));
        set_cmd(16'((en != 0) ? 16'hE700 : 16'h0700));
        dl = (en != 0) ? f + 1 : 1;
        dt = (en != 0) ? 8 - f : 1;
        dg = (en != 0) ? ((f + 3) & 7) + 1 : 1;
        sword = 32'h5A; scnt = 0;
        wr(A_DATA, 32'h3C);
        do rd(A_STAT, v); while (!v[5]);
        wr(A_DATA, 32'h96);
        wait_end();
        check("R5 lead", 32'(lead_obs), 32'(2 * dl + 1));
        check("R5 trail", 32'(trail_obs), 32'(2 * dt));
        check("R5 gap", 32'(gap_obs), 32'(2 * dg));
        flush();
      end
    wr(A_DLY, 32'h0);

    // R7 overrun
    set_cmd(16'h0700);
    flush();
    send(32'h11, 32'hA1);
    send(32'h22, 32'hB2);
    rd(A_STAT, v);
    check("R7 overrun set", 32'(v[0]), 32'h1);
    rd(A_DATA, v);
    check("R7 older word kept", v, 32'hA1);
    wr(A_STAT, 32'hFE);
    rd(A_STAT, v);
    check("R7 overrun cleared", 32'(v[0]), 32'h0);

    // R8 transmit only
    wr(A_CTRL, 32'h3);
    send(32'h6B, 32'hFF);
    rd(A_STAT, v);
    check("R8 no receive-full", 32'(v[7]), 32'h0);
    check("R8 still transmits", cap_word, 32'h6B);

    // R9 loopback
    wr(A_CTRL, 32'h11);
    send(32'hC3, 32'h00);
    rd(A_DATA, v);
    check("R9 inverted loop", v, 32'h3C);
    wr(A_CTRL, 32'h31);
    send(32'hC3, 32'h00);
    rd(A_DATA, v);
    check("R9 straight loop", v, 32'hC3);

    // R10 idle level
    wr(A_CTRL, 32'hC1);
    send(32'h00, 32'h0);
    check("R10 idle high", 32'(mosi), 32'h1);
    wr(A_CTRL, 32'h41);
    send(32'hFF, 32'h0);
    check("R10 idle low", 32'(mosi), 32'h0);
    flush();

    // R11 R13 enable gating and interrupts
    wr(A_CTRL, 32'h0C);
    check("R13 irq_tx when empty", 32'(irq_tx), 32'h1);
    w0 = words;
    sword = 32'h81; scnt = 0;
    wr(A_DATA, 32'h7E);
    repeat (30) @(negedge clk);
    check("R11 held while disabled", 32'(ss_n), 32'h1);
    rd(A_STAT, v);
    check("R11 status pending", v & 32'h62, 32'h02);
    check("R13 irq_tx when full", 32'(irq_tx), 32'h0);
    wr(A_CTRL, 32'h0D);
    wait_end();
    check("R11 launched after enable", 32'(words - w0), 32'h1);
    check("R13 irq_rx on full", 32'(irq_rx), 32'h1);
    rd(A_DATA, v);
    check("R13 irq_rx cleared", 32'(irq_rx), 32'h0);

    // R12 select keep
    wr(A_CTRL, 32'h1);
    set_cmd(16'h0780);
    r0 = rises;
    send(32'hA5, 32'h5A);
    check("R12 select held", 32'(ss_n), 32'h0);
    send(32'h3C, 32'hC3);
    check("R12 no release between", 32'(rises - r0), 32'h0);
    check("R12 second word", cap_word, 32'h3C);
    wr(A_CMD, 32'h0700);
    repeat (10) @(negedge clk);
    check("R12 released", 32'(ss_n), 32'h1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule